// File: doc/BRIEF.md
# Two-Core Interrupt Flag Router

This block holds six sticky interrupt flags raised by upstream filter outputs and decides which of two processor cores sees them. One core is the user core and the other is the DSP core. Each filter pulses its set line for one cycle. The matching flag then stays set until the core that owns the flags clears it by writing a one to its bit. Flags are gated onto the interrupt line in pairs, and each pair has its own enable bit.

A single core-select bit in the control word chooses which core receives the interrupt request. The same bit decides which core may clear flags. Only the user core may change that bit. Both cores reach the block through their own write port. Each write carries a core identifier, a register choice (control word or flag clear) and a data word. The current flags are always visible on a readback port.

Top module: `irq_flag_router`

## Requirements
- R1: Reset clears all six flags, all three pair enables and the core-select bit, and drives both interrupt requests to 0.
- R2: When a set pulse arrives on `flag_set[i]`, flag i is 1 from the next rising edge. It stays 1 until a clear write from the owning core.
- R3: A flag-clear write (`wr_reg`=1) from the core whose identifier equals the core-select bit (`wr_core` 0 = user, 1 = DSP) clears, on that edge, every flag i whose data bit i is 1. Flags whose data bit is 0 are left alone.
- R4: A flag-clear write from the core that does not own the flags leaves every flag unchanged.
- R5: If a set pulse and an owning clear hit the same flag in the same cycle, the flag ends up set.
- R6: A control write (`wr_reg`=0) loads the pair enables from data bits 12 (flags 1:0), 13 (flags 3:2) and 14 (flags 5:4). The interrupt request is the OR of every set flag whose pair enable is 1. Disabled flags still set and read back.
- R7: With the core-select bit (control data bit 15) at 0, only `irq_user` may assert and `irq_dsp` is 0. With it at 1, only `irq_dsp` may assert and `irq_user` is 0.
- R8: The core-select bit changes only on a control write carrying the user identifier (0). A DSP control write updates the pair enables and leaves the select bit unchanged.
- R9: If both ports write the control word in the same cycle, port 0 supplies the pair enables. Port 0 also supplies the select bit if it carries the user identifier; otherwise port 1 supplies it if port 1 carries the user identifier.
- R10: Every flag and control change takes effect at the rising edge that samples the write or pulse, not before it. The interrupt requests follow the registered state with no further cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p0_wr_en | input | 1 | Port 0 write strobe |
| p0_wr_reg | input | 1 | Port 0 target: 0 control word, 1 flag clear |
| p0_wr_core | input | 1 | Port 0 writer identity: 0 user, 1 DSP |
| p0_wr_data | input | 16 | Port 0 write data |
| p1_wr_en | input | 1 | Port 1 write strobe |
| p1_wr_reg | input | 1 | Port 1 target: 0 control word, 1 flag clear |
| p1_wr_core | input | 1 | Port 1 writer identity: 0 user, 1 DSP |
| p1_wr_data | input | 16 | Port 1 write data |
| flag_set | input | 6 | One-cycle set pulses from the filters |
| irq_user | output | 1 | Interrupt request to the user core |
| irq_dsp | output | 1 | Interrupt request to the DSP core |
| flag_rd | output | 6 | Current flag state |

## Verification
Each write and set pulse is applied half a period before a rising edge. The flag readback and both requests are due just after that same edge, because the flags, enables and select bit are single registers and the requests are combinational from them. Every check therefore samples one nanosecond after the edge that takes the stimulus. The timing test also samples before that edge, to confirm nothing has moved early. The asynchronous reset check samples while reset is still held, with no clock edge in between.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

   typedef enum logic {
      CORE_USER = 1'b0,
      CORE_DSP  = 1'b1
   } core_id_e;

   typedef enum logic {
      REG_CTRL  = 1'b0,
      REG_FLAGS = 1'b1
   } reg_target_e;

   // Expands a per-group enable vector into a per-flag mask.
   function automatic logic [63:0] spread_groups(input logic [63:0] grp,
                                                 input int unsigned groups,
                                                 input int unsigned width);
      logic [63:0] m;
      m = '0;
      for (int g = 0; g < groups; g++) begin
         for (int k = 0; k < width; k++) begin
            m[g*width + k] = grp[g];
         end
      end
      return m;
   endfunction

endpackage

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
   import irq_route_pkg::*;
#(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned NUM_PORTS  = 2,
   parameter int unsigned NUM_GROUPS = 3,
   parameter int unsigned EN_LSB     = 12,
   parameter int unsigned SEL_POS    = 15
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_PORTS-1:0]          ctl_wr,
   input  logic [NUM_PORTS-1:0]          ctl_user,
   input  logic [NUM_PORTS*DATA_W-1:0]   wr_data,
   output logic [NUM_GROUPS-1:0]         grp_en,
   output logic                          core_sel
);

   localparam int unsigned EN_MSB = EN_LSB + NUM_GROUPS - 1;

   if (EN_MSB >= DATA_W) begin : g_bad_en
      $error("irq_ctrl_reg: enable field exceeds data width");
   end
   if (SEL_POS >= DATA_W) begin : g_bad_sel
      $error("irq_ctrl_reg: select bit outside data width");
   end
   if (SEL_POS >= EN_LSB && SEL_POS <= EN_MSB) begin : g_overlap
      $error("irq_ctrl_reg: select bit overlaps enable field");
   end

   logic [NUM_GROUPS-1:0] en_nxt;
   logic                  sel_nxt;

   // Walk ports from highest index down so the lowest port wins.
   always_comb begin
      en_nxt  = grp_en;
      sel_nxt = core_sel;
      for (int p = NUM_PORTS - 1; p >= 0; p--) begin
         if (ctl_wr[p]) begin
            en_nxt = wr_data[p*DATA_W + EN_LSB +: NUM_GROUPS];
         end
         if (ctl_wr[p] && ctl_user[p]) begin
            sel_nxt = wr_data[p*DATA_W + SEL_POS];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grp_en   <= '0;
         core_sel <= CORE_USER;
      end else begin
         grp_en   <= en_nxt;
         core_sel <= sel_nxt;
      end
   end

endmodule

// File: rtl/irq_clr_decode.sv
module irq_clr_decode
   import irq_route_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned NUM_PORTS = 2,
   parameter int unsigned NUM_FLAGS = 6
) (
   input  logic [NUM_PORTS-1:0]        wr_en,
   input  logic [NUM_PORTS-1:0]        wr_reg,
   input  logic [NUM_PORTS-1:0]        wr_core,
   input  logic [NUM_PORTS*DATA_W-1:0] wr_data,
   input  logic                        owner,
   output logic [NUM_FLAGS-1:0]        clr_mask
);

   if (NUM_FLAGS > DATA_W) begin : g_bad_w
      $error("irq_clr_decode: more flags than data bits");
   end

   logic [NUM_PORTS-1:0]   port_ok;
   logic [NUM_FLAGS-1:0]   port_bits [NUM_PORTS];

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      // A port may clear only when its writer is the current owner.
      assign port_ok[p]   = wr_en[p]
                            && (reg_target_e'(wr_reg[p]) == REG_FLAGS)
                            && (wr_core[p] == owner);
      assign port_bits[p] = port_ok[p] ? wr_data[p*DATA_W +: NUM_FLAGS]
                                       : '0;
   end

   always_comb begin
      clr_mask = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         clr_mask = clr_mask | port_bits[p];
      end
   end

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int unsigned NUM_FLAGS = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_FLAGS-1:0] set_pulse,
   input  logic [NUM_FLAGS-1:0] clr_mask,
   output logic [NUM_FLAGS-1:0] flags
);

   if (NUM_FLAGS == 0) begin : g_bad_n
      $error("irq_flag_bank: needs at least one flag");
   end

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flags[i] <= 1'b0;
         end else if (set_pulse[i]) begin
            flags[i] <= 1'b1;          // set dominates a same-cycle clear
         end else if (clr_mask[i]) begin
            flags[i] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/irq_req_route.sv
module irq_req_route
   import irq_route_pkg::*;
#(
   parameter int unsigned NUM_FLAGS  = 6,
   parameter int unsigned GRP_WIDTH  = 2,
   parameter bit          REG_IRQ    = 1'b0,
   localparam int unsigned NUM_GROUPS = NUM_FLAGS / GRP_WIDTH
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_FLAGS-1:0]  flags,
   input  logic [NUM_GROUPS-1:0] grp_en,
   input  logic                  core_sel,
   output logic                  irq_user,
   output logic                  irq_dsp
);

   if (NUM_FLAGS > 64) begin : g_bad_n
      $error("irq_req_route: flag count above 64");
   end

   logic [63:0]           en_wide;
   logic [NUM_FLAGS-1:0]  live;
   logic [NUM_GROUPS-1:0] grp_hit;
   logic                  any_req;
   logic                  user_d;
   logic                  dsp_d;

   assign en_wide = spread_groups(64'(grp_en), NUM_GROUPS, GRP_WIDTH);
   assign live    = flags & en_wide[NUM_FLAGS-1:0];

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      assign grp_hit[g] = |live[g*GRP_WIDTH +: GRP_WIDTH];
   end

   assign any_req = |grp_hit;
   assign user_d  = any_req && (core_id_e'(core_sel) == CORE_USER);
   assign dsp_d   = any_req && (core_id_e'(core_sel) == CORE_DSP);

   if (REG_IRQ) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_user <= 1'b0;
            irq_dsp  <= 1'b0;
         end else begin
            irq_user <= user_d;
            irq_dsp  <= dsp_d;
         end
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign irq_user   = user_d;
      assign irq_dsp    = dsp_d;
   end

   logic unused_hi;
   assign unused_hi = ^en_wide;

endmodule

// File: rtl/irq_flag_router.sv
module irq_flag_router
   import irq_route_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned NUM_FLAGS = 6,
   parameter int unsigned GRP_WIDTH = 2,
   parameter int unsigned EN_LSB    = 12,
   parameter int unsigned SEL_POS   = 15,
   parameter bit          REG_IRQ   = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 p0_wr_en,
   input  logic                 p0_wr_reg,
   input  logic                 p0_wr_core,
   input  logic [DATA_W-1:0]    p0_wr_data,
   input  logic                 p1_wr_en,
   input  logic                 p1_wr_reg,
   input  logic                 p1_wr_core,
   input  logic [DATA_W-1:0]    p1_wr_data,
   input  logic [NUM_FLAGS-1:0] flag_set,
   output logic                 irq_user,
   output logic                 irq_dsp,
   output logic [NUM_FLAGS-1:0] flag_rd
);

   localparam int unsigned NUM_PORTS  = 2;
   localparam int unsigned NUM_GROUPS = NUM_FLAGS / GRP_WIDTH;

   if (GRP_WIDTH == 0 || (NUM_FLAGS % GRP_WIDTH) != 0) begin : g_bad_grp
      $error("irq_flag_router: flags must split evenly into groups");
   end

   logic [NUM_PORTS-1:0]        wr_en_v;
   logic [NUM_PORTS-1:0]        wr_reg_v;
   logic [NUM_PORTS-1:0]        wr_core_v;
   logic [NUM_PORTS*DATA_W-1:0] wr_data_v;
   logic [NUM_PORTS-1:0]        ctl_wr_v;
   logic [NUM_PORTS-1:0]        ctl_user_v;
   logic [NUM_GROUPS-1:0]       grp_en_q;
   logic                        core_sel_q;
   logic [NUM_FLAGS-1:0]        clr_mask;

   assign wr_en_v   = {p1_wr_en,   p0_wr_en};
   assign wr_reg_v  = {p1_wr_reg,  p0_wr_reg};
   assign wr_core_v = {p1_wr_core, p0_wr_core};
   assign wr_data_v = {p1_wr_data, p0_wr_data};

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_ctl
      assign ctl_wr_v[p]   = wr_en_v[p]
                             && (reg_target_e'(wr_reg_v[p]) == REG_CTRL);
      assign ctl_user_v[p] = (core_id_e'(wr_core_v[p]) == CORE_USER);
   end

   irq_ctrl_reg #(
      .DATA_W     (DATA_W),
      .NUM_PORTS  (NUM_PORTS),
      .NUM_GROUPS (NUM_GROUPS),
      .EN_LSB     (EN_LSB),
      .SEL_POS    (SEL_POS)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_wr   (ctl_wr_v),
      .ctl_user (ctl_user_v),
      .wr_data  (wr_data_v),
      .grp_en   (grp_en_q),
      .core_sel (core_sel_q)
   );

   irq_clr_decode #(
      .DATA_W    (DATA_W),
      .NUM_PORTS (NUM_PORTS),
      .NUM_FLAGS (NUM_FLAGS)
   ) u_clr (
      .wr_en    (wr_en_v),
      .wr_reg   (wr_reg_v),
      .wr_core  (wr_core_v),
      .wr_data  (wr_data_v),
      .owner    (core_sel_q),
      .clr_mask (clr_mask)
   );

   irq_flag_bank #(
      .NUM_FLAGS (NUM_FLAGS)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_pulse (flag_set),
      .clr_mask  (clr_mask),
      .flags     (flag_rd)
   );

   irq_req_route #(
      .NUM_FLAGS (NUM_FLAGS),
      .GRP_WIDTH (GRP_WIDTH),
      .REG_IRQ   (REG_IRQ)
   ) u_route (
      .clk      (clk),
      .rst_n    (rst_n),
      .flags    (flag_rd),
      .grp_en   (grp_en_q),
      .core_sel (core_sel_q),
      .irq_user (irq_user),
      .irq_dsp  (irq_dsp)
   );

endmodule

// File: rtl/irq_flag_router_chk.sv
module irq_flag_router_chk #(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned NUM_FLAGS = 6,
   parameter bit          REG_IRQ   = 1'b0
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 p0_wr_en,
   input logic                 p0_wr_reg,
   input logic                 p0_wr_core,
   input logic [DATA_W-1:0]    p0_wr_data,
   input logic                 p1_wr_en,
   input logic                 p1_wr_reg,
   input logic                 p1_wr_core,
   input logic [DATA_W-1:0]    p1_wr_data,
   input logic [NUM_FLAGS-1:0] flag_set,
   input logic                 irq_user,
   input logic                 irq_dsp,
   input logic [NUM_FLAGS-1:0] flag_rd,
   input logic                 core_sel
);

   logic [NUM_FLAGS-1:0] own_clr;
   logic                 user_ctl;

   always_comb begin
      own_clr = '0;
      if (p0_wr_en && p0_wr_reg && (p0_wr_core == core_sel)) begin
         own_clr = own_clr | p0_wr_data[NUM_FLAGS-1:0];
      end
      if (p1_wr_en && p1_wr_reg && (p1_wr_core == core_sel)) begin
         own_clr = own_clr | p1_wr_data[NUM_FLAGS-1:0];
      end
   end

   assign user_ctl = (p0_wr_en && !p0_wr_reg && !p0_wr_core)
                  || (p1_wr_en && !p1_wr_reg && !p1_wr_core);

   p_reset_state_r1: assert property (@(posedge clk)
      !rst_n |=> (flag_rd == '0 && !irq_user && !irq_dsp));

   // R5 is covered too: a set pulse always leaves its flag high.
   p_set_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_set != '0) |=> ((flag_rd & $past(flag_set)) == $past(flag_set)));

   p_owner_clear_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(flag_rd) & ~flag_rd) & ~$past(own_clr)) == '0));

   p_no_flag_no_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_rd == '0 && $past(flag_rd) == '0) |-> (!irq_user && !irq_dsp));

   p_sel_user_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !user_ctl |=> $stable(core_sel));

   if (!REG_IRQ) begin : g_comb_route
      p_route_side_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (core_sel ? !irq_user : !irq_dsp));
   end

   logic unused_hi;
   assign unused_hi = ^{p0_wr_data, p1_wr_data};

endmodule

bind irq_flag_router irq_flag_router_chk #(
   .DATA_W    (DATA_W),
   .NUM_FLAGS (NUM_FLAGS),
   .REG_IRQ   (REG_IRQ)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .p0_wr_en   (p0_wr_en),
   .p0_wr_reg  (p0_wr_reg),
   .p0_wr_core (p0_wr_core),
   .p0_wr_data (p0_wr_data),
   .p1_wr_en   (p1_wr_en),
   .p1_wr_reg  (p1_wr_reg),
   .p1_wr_core (p1_wr_core),
   .p1_wr_data (p1_wr_data),
   .flag_set   (flag_set),
   .irq_user   (irq_user),
   .irq_dsp    (irq_dsp),
   .flag_rd    (flag_rd),
   .core_sel   (core_sel_q)
);

// File: tb/irq_flag_router_test.sv
module irq_flag_router_test;

   typedef struct packed {
      logic        a_en;
      logic        a_reg;
      logic        a_core;
      logic [15:0] a_data;
      logic        b_en;
      logic        b_reg;
      logic        b_core;
      logic [15:0] b_data;
      logic [5:0]  set;
      logic [5:0]  exp_flags;
      logic        exp_user;
      logic        exp_dsp;
      logic [3:0]  req;
   } vec_t;

   localparam int NVEC = 14;
   // reg: 0 control, 1 flag clear; core: 0 user, 1 DSP
   localparam vec_t VEC [NVEC] = '{
      '{1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0,1'b0,16'h0000, 6'h01, 6'h01,1'b0,1'b0, 4'd2}, // R2 set, no enable
      '{1'b1,1'b0,1'b0,16'h1000, 1'b0,1'b0,1'b0,16'h0000, 6'h00, 6'h01,1'b1,1'b0, 4'd6}, // R6 pair 1:0 on
      '{1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0,1'b0,16'h0000, 6'h20, 6'h21,1'b1,1'b0, 4'd2}, // R2 flag5
      '{1'b0,1'b0,1'b0,16'h0000, 1'b1,1'b0,1'b1,16'h9000, 6'h00, 6'h21,1'b1,1'b0, 4'd8}, // R8 DSP select ignored
      '{1'b0,1'b0,1'b0,16'h0000, 1'b1,1'b1,1'b1,16'h0001, 6'h00, 6'h21,1'b1,1'b0, 4'd4}, // R4 DSP not owner
      '{1'b1,1'b1,1'b0,16'h0001, 1'b0,1'b0,1'b0,16'h0000, 6'h00, 6'h20,1'b0,1'b0, 4'd3}, // R3 user clears flag0
      '{1'b1,1'b0,1'b0,16'hC000, 1'b0,1'b0,1'b0,16'h0000, 6'h00, 6'h20,1'b0,1'b1, 4'd7}, // R7 route to DSP
      '{1'b1,1'b1,1'b0,16'h0020, 1'b0,1'b0,1'b0,16'h0000, 6'h00, 6'h20,1'b0,1'b1, 4'd4}, // R4 user not owner
      '{1'b0,1'b0,1'b0,16'h0000, 1'b1,1'b1,1'b1,16'h0020, 6'h20, 6'h20,1'b0,1'b1, 4'd5}, // R5 set beats clear
      '{1'b0,1'b0,1'b0,16'h0000, 1'b1,1'b1,1'b1,16'h0020, 6'h00, 6'h00,1'b0,1'b0, 4'd3}, // R3 DSP clears
      '{1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0,1'b0,16'h0000, 6'h0C, 6'h0C,1'b0,1'b0, 4'd6}, // R6 pair 3:2 off
      '{1'b1,1'b0,1'b0,16'h2000, 1'b1,1'b0,1'b1,16'h8000, 6'h00, 6'h0C,1'b1,1'b0, 4'd9}, // R9 port0 wins
      '{1'b1,1'b0,1'b1,16'h2000, 1'b1,1'b0,1'b0,16'hA000, 6'h00, 6'h0C,1'b0,1'b1, 4'd9}, // R9 select from port1
      '{1'b1,1'b1,1'b1,16'h0008, 1'b1,1'b1,1'b1,16'h0004, 6'h00, 6'h00,1'b0,1'b0, 4'd3}  // R3 both ports clear
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        p0_wr_en = 1'b0, p0_wr_reg = 1'b0, p0_wr_core = 1'b0;
   logic [15:0] p0_wr_data = '0;
   logic        p1_wr_en = 1'b0, p1_wr_reg = 1'b0, p1_wr_core = 1'b0;
   logic [15:0] p1_wr_data = '0;
   logic [5:0]  flag_set = '0;
   logic        irq_user, irq_dsp;
   logic [5:0]  flag_rd;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   irq_flag_router uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .p0_wr_en   (p0_wr_en),
      .p0_wr_reg  (p0_wr_reg),
      .p0_wr_core (p0_wr_core),
      .p0_wr_data (p0_wr_data),
      .p1_wr_en   (p1_wr_en),
      .p1_wr_reg  (p1_wr_reg),
      .p1_wr_core (p1_wr_core),
      .p1_wr_data (p1_wr_data),
      .flag_set   (flag_set),
      .irq_user   (irq_user),
      .irq_dsp    (irq_dsp),
      .flag_rd    (flag_rd)
   );

   task automatic check(input string req, input logic [5:0] ef,
                        input logic eu, input logic ed);
      checks++;
      if (flag_rd !== ef || irq_user !== eu || irq_dsp !== ed) begin
         fails++;
         $display("FAIL %s: flags=%h user=%b dsp=%b expected flags=%h user=%b dsp=%b",
                  req, flag_rd, irq_user, irq_dsp, ef, eu, ed);
      end
   endtask

   task automatic drive(input vec_t v);
      p0_wr_en = v.a_en;  p0_wr_reg = v.a_reg; p0_wr_core = v.a_core; p0_wr_data = v.a_data;
      p1_wr_en = v.b_en;  p1_wr_reg = v.b_reg; p1_wr_core = v.b_core; p1_wr_data = v.b_data;
      flag_set = v.set;
   endtask

   task automatic idle();
      drive('0);
   endtask

   initial begin
      #1;
      check("R1", 6'h00, 1'b0, 1'b0);            // R1 reset state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         drive(VEC[i]);
         @(posedge clk);
         #1;
         idle();
         check($sformatf("R%0d vec%0d", VEC[i].req, i),
               VEC[i].exp_flags, VEC[i].exp_user, VEC[i].exp_dsp);
      end
      // State now: flags 0, pair 3:2 enabled, select = DSP.

      // R10: a pulse is not visible before its edge.
      @(negedge clk);
      flag_set = 6'h02;
      #1;
      check("R10 early", 6'h00, 1'b0, 1'b0);
      @(posedge clk);
      #1;
      idle();
      check("R10 edge", 6'h02, 1'b0, 1'b0);      // pair 1:0 disabled

      // R7/R6: user write enables pair 1:0 and returns select to user.
      @(negedge clk);
      p1_wr_en = 1'b1; p1_wr_reg = 1'b0; p1_wr_core = 1'b0; p1_wr_data = 16'h1000;
      @(posedge clk);
      #1;
      idle();
      check("R7 back to user", 6'h02, 1'b1, 1'b0);

      // R1: asynchronous reset mid-run.
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1 mid-run", 6'h00, 1'b0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      flag_set = 6'h01;
      @(posedge clk);
      #1;
      idle();
      check("R1 enables cleared", 6'h01, 1'b0, 1'b0);
      @(negedge clk);
      p0_wr_en = 1'b1; p0_wr_reg = 1'b0; p0_wr_core = 1'b0; p0_wr_data = 16'h1000;
      @(posedge clk);
      #1;
      idle();
      check("R1 select cleared", 6'h01, 1'b1, 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (2000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule